// File: doc/BRIEF.md
# Delay-Tap Phase-Shift Symbol Receiver

This block recovers bits that an external agent signals by loading the strobe lines of a memory interface. The memory controller re-runs its read-timing calibration periodically and settles on an input-delay tap value for each strobe group. Extra load on a group's strobe delays its rising edge. Because the whole group is aligned to that edge, the calibration compensates by picking a smaller tap value for the group. The receiver compares each group's current tap value with a baseline stored earlier and turns a large enough drop into a 1.

The baseline is stored from an unloaded calibration result when a capture command arrives. After that, every recalibration-done pulse produces one bit per group and a one-cycle valid strobe. The defaults are eight groups and a recalibration rate of 1 kHz, which gives 8 kbit/s. A group whose tap value has moved too far from its baseline, in either direction, raises an error flag for that update. Such a shift exceeds the usable skew of about a quarter clock period (12 taps of 78.125 ps), and read data would be at risk.

Top module: `tsr_rx`

## Requirements
- R1: While reset is asserted, bits_o, err_o and valid_o are all zero.
- R2: After a baseline exists, valid_o is high for exactly the one cycle that follows each cycle with recal_done_i high. Back-to-back pulses give back-to-back valid cycles. valid_o is low in every other cycle.
- R3: A recal_done_i pulse that arrives before any baseline capture produces no valid_o and leaves bits_o and err_o unchanged.
- R4: Group g reads its 6-bit unsigned tap value from tap_i[6g+5:6g]. On an update, bits_o[g] is 1 when the baseline minus the current tap is at least 3.
- R5: On an update, bits_o[g] is 0 when the drop from the baseline is below 3. This includes an unchanged tap and a tap that rose by any amount.
- R6: On an update, err_o[g] is 1 when the current tap differs from the baseline by more than 12 in either direction. A difference of exactly 12 gives 0.
- R7: bits_o and err_o change only in the cycle that follows a recal_done_i pulse. Otherwise they hold their values.
- R8: When base_cap_i is high at a clock edge, every group's baseline is replaced by its current tap value. If recal_done_i is high in the same cycle, that update is decoded against the previous baseline.
- R9: Each group is decoded only from its own tap field and its own baseline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_cap_i | input | 1 | Store the current taps as the baseline |
| recal_done_i | input | 1 | One-cycle pulse: calibration results are current |
| tap_i | input | 48 | Tap value per group, 6 bits each, group 0 in the low bits |
| bits_o | output | 8 | Decoded bit per group |
| err_o | output | 8 | Per-group excessive-shift flag |
| valid_o | output | 1 | One-cycle strobe: bits_o and err_o updated |

## Verification
A stored baseline that is stale or was taken from the wrong cycle shows up at the first update after the capture. It appears as flipped bits or false error flags on exactly the groups whose taps were stored wrongly. A missing or stuck baseline-present flag shows in one cycle: valid_o appears before a capture, or never appears after one. Sign or threshold faults in the compare stay hidden until a tap sits exactly 3 or 12 taps from its baseline, or moves upward. The stimulus therefore places groups on those boundaries in both directions, with baselines near both ends of the tap range.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  typedef struct packed {
    logic sym;
    logic err;
  } tsr_dec_t;
endpackage

// File: rtl/tsr_base_bank.sv
module tsr_base_bank #(
  parameter int unsigned N_GRP = 8,
  parameter int unsigned TAP_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_i,
  input  logic [N_GRP*TAP_W-1:0] tap_i,
  output logic [N_GRP*TAP_W-1:0] base_o,
  output logic                   have_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    base_o[g*TAP_W +: TAP_W] <= '0;
      else if (cap_i) base_o[g*TAP_W +: TAP_W] <= tap_i[g*TAP_W +: TAP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    have_o <= 1'b0;
    else if (cap_i) have_o <= 1'b1;
  end
endmodule

// File: rtl/tsr_group_dec.sv
module tsr_group_dec
  import tsr_pkg::*;
#(
  parameter int unsigned TAP_W    = 6,
  parameter int unsigned DECIDE_T = 3,
  parameter int unsigned MAX_SKEW = 12
) (
  input  logic [TAP_W-1:0] base_i,
  input  logic [TAP_W-1:0] tap_i,
  output tsr_dec_t         dec_o
);
  localparam int unsigned DW = TAP_W + 1;
  localparam logic signed [DW-1:0] DEC_S = DW'(DECIDE_T);
  localparam logic signed [DW-1:0] MAX_S = DW'(MAX_SKEW);

  logic signed [DW-1:0] drop;

  // positive drop = tap fell = strobe loaded
  assign drop = $signed({1'b0, base_i}) - $signed({1'b0, tap_i});

  always_comb begin
    dec_o.sym = (drop >= DEC_S);
    dec_o.err = (drop > MAX_S) || (drop < -MAX_S);
  end
endmodule

// File: rtl/tsr_out_stage.sv
module tsr_out_stage #(
  parameter int unsigned N_GRP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [N_GRP-1:0] sym_i,
  input  logic [N_GRP-1:0] err_i,
  output logic [N_GRP-1:0] sym_o,
  output logic [N_GRP-1:0] err_o,
  output logic             vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o <= '0;
      err_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= upd_i;
      if (upd_i) begin
        sym_o <= sym_i;
        err_o <= err_i;
      end
    end
  end
endmodule

// File: rtl/tsr_rx.sv
module tsr_rx
  import tsr_pkg::*;
#(
  parameter int unsigned N_GRP    = 8,
  parameter int unsigned TAP_W    = 6,
  parameter int unsigned DECIDE_T = 3,
  parameter int unsigned MAX_SKEW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   base_cap_i,
  input  logic                   recal_done_i,
  input  logic [N_GRP*TAP_W-1:0] tap_i,
  output logic [N_GRP-1:0]       bits_o,
  output logic [N_GRP-1:0]       err_o,
  output logic                   valid_o
);
  localparam int unsigned BUS_W = N_GRP * TAP_W;

  logic [BUS_W-1:0] base_q;
  logic             have_q;
  logic [N_GRP-1:0] sym_d, err_d;

  tsr_base_bank #(.N_GRP(N_GRP), .TAP_W(TAP_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (base_cap_i),
    .tap_i  (tap_i),
    .base_o (base_q),
    .have_o (have_q)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_dec
    tsr_dec_t dec;
    tsr_group_dec #(
      .TAP_W(TAP_W), .DECIDE_T(DECIDE_T), .MAX_SKEW(MAX_SKEW)
    ) u_dec (
      .base_i (base_q[g*TAP_W +: TAP_W]),
      .tap_i  (tap_i[g*TAP_W +: TAP_W]),
      .dec_o  (dec)
    );
    assign sym_d[g] = dec.sym;
    assign err_d[g] = dec.err;
  end

  // same-cycle capture: old baseline still in base_q here
  tsr_out_stage #(.N_GRP(N_GRP)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (recal_done_i && have_q),
    .sym_i  (sym_d),
    .err_i  (err_d),
    .sym_o  (bits_o),
    .err_o  (err_o),
    .vld_o  (valid_o)
  );
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int unsigned N_GRP = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             base_cap_i,
  input logic             recal_done_i,
  input logic [N_GRP-1:0] bits_o,
  input logic [N_GRP-1:0] err_o,
  input logic             valid_o
);
  logic cap_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cap_seen_q <= 1'b0;
    else if (base_cap_i) cap_seen_q <= 1'b1;
  end

  p_valid_follows_recal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(recal_done_i));

  p_no_spurious_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(recal_done_i) |-> !valid_o);

  p_no_valid_before_base_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cap_seen_q);

  p_hold_between_updates_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(bits_o) && $stable(err_o)));
endmodule

bind tsr_rx tsr_checker #(.N_GRP(N_GRP)) u_chk (.*);

// File: tb/tsr_rx_bench.sv
module tsr_rx_bench;
  localparam int NG = 8;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap = 1'b0, rec = 1'b0;
  logic [NG*TW-1:0] taps = '0;
  logic [NG-1:0] bits, errs;
  logic vld;

  int n_chk = 0, n_err = 0, cyc = 0;
  int m_base[NG];
  bit m_have = 0;
  logic [NG-1:0] e_bits = '0, e_errs = '0;
  logic e_vld = 1'b0;

  always #5 clk = ~clk;

  tsr_rx u_tsr_rx (
    .clk_i(clk), .rst_ni(rst_n), .base_cap_i(cap), .recal_done_i(rec),
    .tap_i(taps), .bits_o(bits), .err_o(errs), .valid_o(vld)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog: run hung, got cyc=%0d expected <20000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic cmp(string tag);
    n_chk++;
    if (bits !== e_bits || errs !== e_errs || vld !== e_vld) begin
      n_err++;
      $display("FAIL %s: got bits=%h err=%h vld=%b expected bits=%h err=%h vld=%b",
               tag, bits, errs, vld, e_bits, e_errs, e_vld);
    end
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit c, input bit r, input int t[NG], input string tag);
    cap = c; rec = r;
    for (int g = 0; g < NG; g++) taps[g*TW +: TW] = TW'(t[g]);
    @(posedge clk);
    e_vld = r && m_have;
    if (r && m_have)
      for (int g = 0; g < NG; g++) begin
        int d = m_base[g] - t[g];
        e_bits[g] = (d >= 3);
        e_errs[g] = (d > 12) || (d < -12);
      end
    if (c) begin
      for (int g = 0; g < NG; g++) m_base[g] = t[g];
      m_have = 1;
    end
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    int t[NG];
    for (int g = 0; g < NG; g++) t[g] = 30;
    repeat (3) @(negedge clk);
    cmp("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release");

    step(0, 1, t, "R3 recal before baseline");
    step(0, 0, t, "R3 idle");
    step(1, 0, t, "R8 capture 30");
    step(0, 1, t, "R5 unchanged taps");
    for (int g = 0; g < NG; g++) t[g] = 27;
    step(0, 1, t, "R4 drop of 3");
    for (int g = 0; g < NG; g++) t[g] = 28;
    step(0, 1, t, "R5 drop of 2 back-to-back R2");
    t = '{30, 27, 18, 17, 42, 43, 29, 26};
    step(0, 1, t, "R9 R6 mixed groups");
    step(0, 0, t, "R7 hold 1");
    t = '{0, 0, 0, 0, 0, 0, 0, 0};
    step(0, 0, t, "R7 hold with taps changed");
    t = '{20, 20, 20, 20, 20, 20, 20, 20};
    step(1, 1, t, "R8 capture with recal uses old base");
    step(0, 1, t, "R8 new base applied");
    t = '{5, 63, 5, 63, 5, 63, 5, 63};
    step(1, 0, t, "R8 recapture edges");
    t = '{63, 0, 8, 60, 2, 51, 17, 50};
    step(0, 1, t, "R6 R4 range extremes");
    step(0, 0, t, "R2 valid drops");
    t = '{5, 63, 5, 63, 5, 63, 5, 63};
    step(0, 1, t, "R5 back to baseline");
    step(0, 0, t, "R7 final hold");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule